// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt Controller

This block turns the state of an SPI peripheral into its interrupt and DMA request flags. It watches the fill counts of the receive and transmit FIFOs, single-cycle error pulses from the datapath, the shift-register-empty state and the slave-select state. From these it keeps a ten-bit flag word. Two bits are request flags that follow the FIFO levels live. Two are plain status bits. Six are sticky error flags.

Software programs a configuration word. That word holds one enable bit per flag, a two-bit threshold code for each FIFO direction and a DMA enable. Software can also write the flag word. A written 0 clears a sticky flag and a written 1 forces it set, so each error interrupt can be raised without a real fault. The single interrupt line is the registered OR of every enabled flag. The two DMA requests mirror the threshold conditions while DMA is enabled.

The FIFO storage, the serial shifter and the bus decode live elsewhere.

Top module: `spi_irq_flag_ctrl`

## Requirements
- R1: Flag bit 0 (receive request) is 1 exactly when `rx_level` is at least the receive threshold. The threshold comes from configuration bits [11:10]: code 0 means 1 entry, 1 means 2, 2 means 4 and 3 means DEPTH (full).
- R2: Flag bit 1 (transmit request) is 1 exactly when the free slots, DEPTH minus `tx_level`, number at least the transmit threshold. The threshold comes from configuration bits [13:12] with the same code meanings, where code 3 means every slot is free.
- R3: Flag bits 0 and 1 follow the current levels and configuration with no register delay. A flag-word write has no effect on them.
- R4: Sticky flag bits 4 to 9 are set by `hw_evt` bits 0 to 5 in the cycle after the pulse. The bits map as follows:
  - 4: receive overrun
  - 5: transmit overrun
  - 6: mode fault
  - 7: underrun
  - 8: receive illegal access
  - 9: transmit illegal access

  A set flag holds until software clears it.
- R5: A flag-word write loads bits 9:4 from `flag_wdata[9:4]`. A written 0 clears the flag and a written 1 forces it set.
- R6: Flag bit 2 equals `shift_empty` and flag bit 3 equals `sel_active`. Both are read-only.
- R7: Configuration bit i (for i from 0 to 9) enables flag bit i. `irq` is 1 in the cycle after any enabled flag is 1, and 0 in the cycle after none is.
- R8: `dma_rx_req` and `dma_tx_req` equal the receive and transmit request conditions while configuration bit 14 is 1. They are 0 while that bit is 0.
- R9: When a `hw_evt` pulse and a flag-word write of 0 hit the same sticky flag in one cycle, the flag ends set.
- R10: While `rst_n` is low, the sticky flags, the configuration and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | CNT_W | Receive FIFO occupancy, 0 to DEPTH |
| tx_level | input | CNT_W | Transmit FIFO occupancy, 0 to DEPTH |
| hw_evt | input | 6 | Single-cycle error pulses, one per sticky flag |
| shift_empty | input | 1 | Shift register and transmit FIFO drained |
| sel_active | input | 1 | Slave select currently asserted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 15 | Configuration word |
| flag_we | input | 1 | Flag-word write strobe |
| flag_wdata | input | 10 | Flag-word write data |
| flags | output | 10 | Current flag word |
| irq | output | 1 | Registered combined interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with its default DEPTH of 8. With that depth the four threshold codes land on four different levels (1, 2, 4 and 8), so each code can be checked on both sides of its boundary: one level below the threshold and exactly at it. A depth of 8 also makes the full threshold distinct from the four-entry one, so a decode that mixes up codes 2 and 3 shows up in the receive and transmit flags.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NFLAG        = 10;
  localparam int NSTICKY      = 6;
  localparam int FIRST_STICKY = 4;
  localparam int CFG_W        = 15;

  localparam int FL_RXREQ = 0;
  localparam int FL_TXREQ = 1;
  localparam int FL_SHEMP = 2;
  localparam int FL_SEL   = 3;

  typedef struct packed {
    logic                 dma_en;
    logic [1:0]           tx_code;
    logic [1:0]           rx_code;
    logic [NFLAG-1:0]     en;
  } cfg_t;

  // threshold code -> number of entries/slots required
  function automatic int thr_count(input logic [1:0] code, input int depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return depth;
    endcase
  endfunction

  // free slots of a FIFO, saturating at zero for out-of-range levels
  function automatic int free_slots(input int level, input int depth);
    return (level >= depth) ? 0 : depth - level;
  endfunction
endpackage

// File: rtl/spi_irq_level_cmp.sv
module spi_irq_level_cmp
  import spi_irq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 4,
  parameter bit COUNT_FREE = 1'b0
) (
  input  logic [CNT_W-1:0] level,
  input  logic [1:0]       code,
  output logic             req
);
  int measure;
  int need;

  generate
    if (COUNT_FREE) begin : g_free
      always_comb measure = free_slots(int'(level), DEPTH);
    end else begin : g_fill
      always_comb measure = int'(level);
    end
  endgenerate

  always_comb begin
    need = thr_count(code, DEPTH);
    req  = (measure >= need);
  end
endmodule

// File: rtl/spi_irq_sticky_bank.sv
module spi_irq_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q[i] <= 1'b0;
        else if (set_ev[i]) q[i] <= 1'b1;      // hardware event has priority
        else if (wr_en)     q[i] <= wr_val[i]; // 0 clears, 1 forces
      end
    end
  endgenerate
endmodule

// File: rtl/spi_irq_combine.sv
module spi_irq_combine #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  output logic         irq_raw,
  output logic         irq
);
  always_comb irq_raw = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_raw;
  end
endmodule

// File: rtl/spi_irq_flag_ctrl.sv
module spi_irq_flag_ctrl
  import spi_irq_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     rx_level,
  input  logic [CNT_W-1:0]     tx_level,
  input  logic [NSTICKY-1:0]   hw_evt,
  input  logic                 shift_empty,
  input  logic                 sel_active,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 flag_we,
  input  logic [NFLAG-1:0]     flag_wdata,
  output logic [NFLAG-1:0]     flags,
  output logic                 irq,
  output logic                 dma_rx_req,
  output logic                 dma_tx_req
);
  cfg_t                cfg_q;
  logic                rx_req;
  logic                tx_req;
  logic [NSTICKY-1:0]  sticky_q;
  logic [NFLAG-1:0]    en_q;
  logic                dma_en_q;
  logic                irq_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  assign en_q     = cfg_q.en;
  assign dma_en_q = cfg_q.dma_en;

  spi_irq_level_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .COUNT_FREE(1'b0)) u_rx_cmp (
    .level (rx_level),
    .code  (cfg_q.rx_code),
    .req   (rx_req)
  );

  spi_irq_level_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .COUNT_FREE(1'b1)) u_tx_cmp (
    .level (tx_level),
    .code  (cfg_q.tx_code),
    .req   (tx_req)
  );

  spi_irq_sticky_bank #(.N(NSTICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (hw_evt),
    .wr_en  (flag_we),
    .wr_val (flag_wdata[NFLAG-1:FIRST_STICKY]),
    .q      (sticky_q)
  );

  always_comb begin
    flags           = '0;
    flags[FL_RXREQ] = rx_req;
    flags[FL_TXREQ] = tx_req;
    flags[FL_SHEMP] = shift_empty;
    flags[FL_SEL]   = sel_active;
    flags[NFLAG-1:FIRST_STICKY] = sticky_q;
  end

  spi_irq_combine #(.N(NFLAG)) u_comb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .en      (en_q),
    .irq_raw (irq_raw),
    .irq     (irq)
  );

  assign dma_rx_req = dma_en_q & rx_req;
  assign dma_tx_req = dma_en_q & tx_req;
endmodule

// File: rtl/spi_irq_flag_chk.sv
module spi_irq_flag_chk
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   rx_level,
  input logic [CNT_W-1:0]   tx_level,
  input logic [NSTICKY-1:0] hw_evt,
  input logic               shift_empty,
  input logic               sel_active,
  input logic               flag_we,
  input logic [NFLAG-1:0]   flag_wdata,
  input logic [NFLAG-1:0]   flags,
  input logic [NFLAG-1:0]   en_q,
  input logic               dma_en_q,
  input logic               irq,
  input logic               dma_rx_req,
  input logic               dma_tx_req
);
  AST_RX_FULL_REQ:   assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == CNT_W'(DEPTH)) |-> flags[FL_RXREQ]);                        // R1
  AST_RX_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !flags[FL_RXREQ]);                                  // R1
  AST_TX_EMPTY_REQ:  assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> flags[FL_TXREQ]);                                   // R2
  AST_TX_FULL_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == CNT_W'(DEPTH)) |-> !flags[FL_TXREQ]);                       // R2
  AST_STATUS_LIVE:   assert property (@(posedge clk) disable iff (!rst_n)
    flags[FL_SEL:FL_SHEMP] == {sel_active, shift_empty});                    // R6
  AST_EVT_SETS:      assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((flags[NFLAG-1:FIRST_STICKY] & $past(hw_evt)) == $past(hw_evt))); // R4
  AST_STICKY_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we && hw_evt == '0) |=> $stable(flags[NFLAG-1:FIRST_STICKY]));   // R4
  AST_WR_LOAD:       assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags[NFLAG-1:FIRST_STICKY] ==
                 ($past(flag_wdata[NFLAG-1:FIRST_STICKY]) | $past(hw_evt)))); // R5
  AST_IRQ_FOLLOW:    assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past(|(flags & en_q))));                              // R7
  AST_DMA_GATED:     assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en_q |-> (!dma_rx_req && !dma_tx_req));                             // R8

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (irq == 1'b0 && flags[NFLAG-1:FIRST_STICKY] == '0); // R10
    end
  end
endmodule

bind spi_irq_flag_ctrl spi_irq_flag_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_level    (rx_level),
  .tx_level    (tx_level),
  .hw_evt      (hw_evt),
  .shift_empty (shift_empty),
  .sel_active  (sel_active),
  .flag_we     (flag_we),
  .flag_wdata  (flag_wdata),
  .flags       (flags),
  .en_q        (en_q),
  .dma_en_q    (dma_en_q),
  .irq         (irq),
  .dma_rx_req  (dma_rx_req),
  .dma_tx_req  (dma_tx_req)
);

// File: tb/sim_spi_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_flag_ctrl;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] rx_level = '0;
  logic [CNT_W-1:0] tx_level = '0;
  logic [5:0]       hw_evt = '0;
  logic             shift_empty = 1'b0;
  logic             sel_active = 1'b0;
  logic             cfg_we = 1'b0;
  logic [14:0]      cfg_wdata = '0;
  logic             flag_we = 1'b0;
  logic [9:0]       flag_wdata = '0;
  logic [9:0]       flags;
  logic             irq;
  logic             dma_rx_req;
  logic             dma_tx_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  spi_irq_flag_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .hw_evt(hw_evt), .shift_empty(shift_empty), .sel_active(sel_active),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .flags(flags), .irq(irq),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  // {rx_code, tx_code, rx_level, tx_level, dma_en, exp_rxreq, exp_txreq}
  localparam logic [14:0] VEC [8] = '{
    {2'd0, 2'd0, 4'd0, 4'd8, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 4'd1, 4'd7, 1'b0, 1'b1, 1'b1},
    {2'd1, 2'd1, 4'd1, 4'd7, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'd1, 4'd2, 4'd6, 1'b1, 1'b1, 1'b1},
    {2'd2, 2'd2, 4'd3, 4'd5, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'd2, 4'd4, 4'd4, 1'b1, 1'b1, 1'b1},
    {2'd3, 2'd3, 4'd7, 4'd1, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd3, 4'd8, 4'd0, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [14:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_flags(input logic [9:0] v);
    @(negedge clk); flag_we = 1'b1; flag_wdata = v;
    @(negedge clk); flag_we = 1'b0;
  endtask

  task automatic pulse(input int idx, input bit with_clear);
    @(negedge clk);
    hw_evt = 6'(1 << idx);
    if (with_clear) begin flag_we = 1'b1; flag_wdata = '0; end
    @(negedge clk);
    hw_evt = '0; flag_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq in reset", irq, 0);
    chk("R10 flags in reset", flags, 10'b0000000010);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 dma after reset", {dma_rx_req, dma_tx_req}, 0);

    // R1 R2 R8 threshold table
    for (int i = 0; i < 8; i++) begin
      logic [14:0] v;
      v = VEC[i];
      wr_cfg({v[2], v[12:11], v[14:13], 10'b0});
      rx_level = v[10:7];
      tx_level = v[6:3];
      #1;
      chk($sformatf("R1 rx request vec %0d", i), flags[0], v[1]);
      chk($sformatf("R2 tx request vec %0d", i), flags[1], v[0]);
      chk($sformatf("R8 dma vec %0d", i), {dma_rx_req, dma_tx_req}, {v[2] & v[1], v[2] & v[0]});
    end

    // R6 status bits follow inputs
    wr_cfg(15'b0);
    rx_level = 0; tx_level = 8;
    @(negedge clk); shift_empty = 1'b1; sel_active = 1'b0; #1;
    chk("R6 shift empty", flags[3:2], 2'b01);
    shift_empty = 1'b0; sel_active = 1'b1; #1;
    chk("R6 select", flags[3:2], 2'b10);

    // R3 R5 force all, request bits unaffected
    wr_flags(10'h3FF);
    chk("R5 force sticky", flags[9:4], 6'h3F);
    chk("R3 requests ignore write", flags[1:0], 2'b00);
    chk("R6 status ignore write", flags[3:2], 2'b10);
    // R5 clear
    wr_flags(10'h000);
    chk("R5 clear sticky", flags[9:4], 6'h00);
    sel_active = 1'b0;

    // R4 event sets and holds
    pulse(2, 1'b0);
    chk("R4 mode fault set", flags[9:4], 6'b000100);
    repeat (3) @(negedge clk);
    chk("R4 mode fault holds", flags[9:4], 6'b000100);
    // R9 hardware beats write of zero
    pulse(0, 1'b1);
    chk("R9 event beats clear", flags[9:4], 6'b000001);

    // R7 enable gating and latency
    chk("R7 no enables", irq, 0);
    wr_cfg(15'b0000000_0001_0000);  // enable bit 4 (rx overrun, set)
    chk("R7 irq one cycle late", irq, 0);
    @(negedge clk);
    chk("R7 irq asserted", irq, 1);
    wr_cfg(15'b0000000_0010_0000);  // enable bit 5 (clear)
    @(negedge clk);
    chk("R7 irq off for clear flag", irq, 0);
    wr_cfg(15'b0000000_0000_0010);  // enable bit 1, tx_level 8 -> no request
    @(negedge clk);
    chk("R7 request not met", irq, 0);
    tx_level = 7;
    @(negedge clk); @(negedge clk);
    chk("R7 tx request irq", irq, 1);

    // R10 mid-run reset
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R10 reset clears sticky", flags[9:4], 0);
    chk("R10 reset clears irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cfg cleared", {dma_rx_req, dma_tx_req, irq}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule